// File: doc/BRIEF.md
# Byte-Parity Protected Cache Line Bank

This block holds the data side of a small cache: a number of lines, each made of several words of bytes. Every stored byte has its own even-parity bit. A line is loaded only as a whole by a fill, which also marks the line valid. After that the line can be read one word at a time. Each read recomputes parity over the returned bytes, compares it with the stored bits and reports the bytes that disagree.

A byte-masked write to a valid line runs as a three-step sequence. First the current word is read out. Next it is checked against its stored parity and merged with the new bytes. Finally the merged word is written back with freshly generated parity. The bank reports busy while this runs and ignores other requests, so the requester must hold them. A write to an invalid line is refused at once. A test port can invert a single stored data bit without touching parity, which lets a bench or a self-test create parity faults on purpose.

Top module: `parity_line_bank`

## Requirements
- R1: After reset every line is invalid and busy, rd_valid, wr_done and wr_reject are low.
- R2: An accepted fill stores the whole line and sets it valid. Parity is generated per byte so that each byte plus its parity bit holds an even number of ones. Word w of a line sits at line bits [w*WBITS +: WBITS], and byte k of a word at word bits [8k+7:8k].
- R3: An accepted read sets rd_valid in the next cycle, with rd_data equal to the word selected by rd_sel.
- R4: On a read, rd_err_mask bit k is 1 exactly when byte k of the returned word disagrees with its stored parity bit. rd_err is the OR of the mask.
- R5: A read of an invalid line sets rd_inval and returns all-zero data and an all-zero error mask.
- R6: A write to a valid line replaces exactly the bytes whose wr_be bit is 1 and keeps the others. It stores new parity for the whole merged word, so a later read of that word reports no error.
- R7: After a write to a valid line is accepted, busy is high for exactly three cycles. wr_done is a one-cycle pulse in the cycle busy drops.
- R8: While busy is high, fill, read, write and inject requests have no effect.
- R9: The wr_err_mask delivered with wr_done flags the bytes of the old word that failed the pre-write parity check. The write is performed even when bytes are flagged. wr_err is the OR of the mask.
- R10: A write to an invalid line raises wr_done and wr_reject in the next cycle without raising busy, and the line stays invalid.
- R11: When requests arrive together, a fill beats a write and a write beats a read. Inject is dropped when a fill or write is accepted and coexists with a read. Dropped requests have no effect.
- R12: An accepted inject inverts data bit inj_bit of the line (line bit b belongs to line byte b/8), and leaves parity and validity unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_en | input | 1 | Fill request |
| fill_idx | input | IDX_W | Line to fill |
| fill_line | input | LBITS | Full line contents |
| rd_en | input | 1 | Word read request |
| rd_idx | input | IDX_W | Line to read |
| rd_sel | input | SEL_W | Word within the line |
| wr_en | input | 1 | Byte-masked write request |
| wr_idx | input | IDX_W | Line to write |
| wr_sel | input | SEL_W | Word within the line |
| wr_data | input | WBITS | New word data |
| wr_be | input | WBYTES | Byte enables |
| inj_en | input | 1 | Bit-flip test request |
| inj_idx | input | IDX_W | Line to corrupt |
| inj_bit | input | BIT_W | Data bit within the line |
| busy | output | 1 | Write sequence running, requests ignored |
| rd_valid | output | 1 | Read response present |
| rd_data | output | WBITS | Read word |
| rd_err_mask | output | WBYTES | Per-byte parity mismatch on read |
| rd_err | output | 1 | Any read byte mismatched |
| rd_inval | output | 1 | Read addressed an invalid line |
| wr_done | output | 1 | Write response present |
| wr_reject | output | 1 | Write refused, line invalid |
| wr_err_mask | output | WBYTES | Per-byte mismatch found before the write |
| wr_err | output | 1 | Any pre-write byte mismatched |

## Verification
The bench builds the bank with four lines of two four-byte words. With so few lines, random traffic keeps revisiting the same lines and words, so fills, injected faults, partial writes and reads overlap on one location often. Both words of a line are reached, as are the first and last line bits. The narrow width still leaves several bytes per word, which is needed to tell flagged bytes from clean ones in both error masks and to cover merges that keep some bytes and replace others.

// File: rtl/pl_pkg.sv
package pl_pkg;

    typedef enum logic [1:0] {
        PW_IDLE,
        PW_READ,
        PW_CHECK,
        PW_WRITE
    } pw_state_e;

    // even parity: stored bit makes the count of ones in byte+bit even
    function automatic logic even_par(input logic [7:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/pl_par_check.sv
module pl_par_check #(
    parameter int WBYTES = 4,
    localparam int WBITS = WBYTES * 8
) (
    input  logic [WBITS-1:0]  data,
    input  logic [WBYTES-1:0] par,
    output logic [WBYTES-1:0] err
);
    import pl_pkg::*;

    for (genvar k = 0; k < WBYTES; k++) begin : g_byte
        assign err[k] = even_par(data[k*8 +: 8]) ^ par[k];
    end

endmodule

// File: rtl/pl_store.sv
module pl_store #(
    parameter int LINES  = 8,
    parameter int WORDS  = 4,
    parameter int WBYTES = 4,
    localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int SEL_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int WBITS  = WBYTES * 8,
    localparam int LBYTES = WORDS * WBYTES,
    localparam int LBITS  = LBYTES * 8,
    localparam int BIT_W  = $clog2(LBITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_we,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [LBITS-1:0]  fill_line,
    input  logic              word_we,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [SEL_W-1:0]  word_sel,
    input  logic [WBITS-1:0]  word_data,
    input  logic [WBYTES-1:0] word_par,
    input  logic              inj_we,
    input  logic [IDX_W-1:0]  inj_idx,
    input  logic [BIT_W-1:0]  inj_bit,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WBITS-1:0]  rd_data,
    output logic [WBYTES-1:0] rd_par,
    output logic [LINES-1:0]  line_valid
);
    import pl_pkg::*;

    logic [LBITS-1:0]  data_q [LINES];
    logic [LBYTES-1:0] par_q  [LINES];
    logic [LINES-1:0]  valid_q;
    logic [LBYTES-1:0] fill_par;

    for (genvar g = 0; g < LBYTES; g++) begin : g_fill_par
        assign fill_par[g] = even_par(fill_line[g*8 +: 8]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                data_q[i] <= '0;
                par_q[i]  <= '0;
            end
        end else begin
            if (fill_we) begin
                data_q[fill_idx]  <= fill_line;
                par_q[fill_idx]   <= fill_par;
                valid_q[fill_idx] <= 1'b1;
            end
            if (word_we) begin
                data_q[word_idx][word_sel*WBITS +: WBITS]  <= word_data;
                par_q[word_idx][word_sel*WBYTES +: WBYTES] <= word_par;
            end
            if (inj_we) begin
                data_q[inj_idx][inj_bit] <= ~data_q[inj_idx][inj_bit];
            end
        end
    end

    assign rd_data    = data_q[rd_idx][rd_sel*WBITS +: WBITS];
    assign rd_par     = par_q[rd_idx][rd_sel*WBYTES +: WBYTES];
    assign line_valid = valid_q;

endmodule

// File: rtl/pl_pw_seq.sv
module pl_pw_seq #(
    parameter int LINES  = 8,
    parameter int WORDS  = 4,
    parameter int WBYTES = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int SEL_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int WBITS = WBYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  st_idx,
    input  logic [SEL_W-1:0]  st_sel,
    input  logic [WBITS-1:0]  st_data,
    input  logic [WBYTES-1:0] st_be,
    input  logic [WBITS-1:0]  old_data,
    input  logic [WBYTES-1:0] old_par,
    output logic              busy,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [SEL_W-1:0]  cur_sel,
    output logic              word_we,
    output logic [WBITS-1:0]  word_data,
    output logic [WBYTES-1:0] word_par,
    output logic              done,
    output logic [WBYTES-1:0] done_mask
);
    import pl_pkg::*;

    pw_state_e         state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [SEL_W-1:0]  sel_q;
    logic [WBITS-1:0]  new_q;
    logic [WBYTES-1:0] be_q;
    logic [WBITS-1:0]  old_q;
    logic [WBYTES-1:0] oldp_q;
    logic [WBITS-1:0]  merged_q;
    logic [WBYTES-1:0] mpar_q;
    logic [WBYTES-1:0] errm_q;
    logic              done_q;
    logic [WBYTES-1:0] dmask_q;

    logic [WBITS-1:0]  merged_c;
    logic [WBYTES-1:0] mpar_c;
    logic [WBYTES-1:0] chk_err;

    // pre-write check of the captured old word
    pl_par_check #(.WBYTES(WBYTES)) u_pre_chk (
        .data (old_q),
        .par  (oldp_q),
        .err  (chk_err)
    );

    for (genvar k = 0; k < WBYTES; k++) begin : g_merge
        assign merged_c[k*8 +: 8] = be_q[k] ? new_q[k*8 +: 8] : old_q[k*8 +: 8];
        assign mpar_c[k]          = even_par(merged_c[k*8 +: 8]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PW_IDLE;
            idx_q    <= '0;
            sel_q    <= '0;
            new_q    <= '0;
            be_q     <= '0;
            old_q    <= '0;
            oldp_q   <= '0;
            merged_q <= '0;
            mpar_q   <= '0;
            errm_q   <= '0;
            done_q   <= 1'b0;
            dmask_q  <= '0;
        end else begin
            done_q  <= (state_q == PW_WRITE);
            dmask_q <= (state_q == PW_WRITE) ? errm_q : '0;
            unique case (state_q)
                PW_IDLE: begin
                    if (start) begin
                        idx_q   <= st_idx;
                        sel_q   <= st_sel;
                        new_q   <= st_data;
                        be_q    <= st_be;
                        state_q <= PW_READ;
                    end
                end
                PW_READ: begin
                    old_q   <= old_data;
                    oldp_q  <= old_par;
                    state_q <= PW_CHECK;
                end
                PW_CHECK: begin
                    errm_q   <= chk_err;
                    merged_q <= merged_c;
                    mpar_q   <= mpar_c;
                    state_q  <= PW_WRITE;
                end
                PW_WRITE: begin
                    state_q <= PW_IDLE;
                end
                default: state_q <= PW_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != PW_IDLE);
    assign cur_idx   = idx_q;
    assign cur_sel   = sel_q;
    assign word_we   = (state_q == PW_WRITE);
    assign word_data = merged_q;
    assign word_par  = mpar_q;
    assign done      = done_q;
    assign done_mask = dmask_q;

endmodule

// File: rtl/parity_line_bank.sv
module parity_line_bank #(
    parameter int LINES  = 8,
    parameter int WORDS  = 4,
    parameter int WBYTES = 4,
    localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int SEL_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int WBITS  = WBYTES * 8,
    localparam int LBITS  = WORDS * WBYTES * 8,
    localparam int BIT_W  = $clog2(LBITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [LBITS-1:0]  fill_line,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WBITS-1:0]  wr_data,
    input  logic [WBYTES-1:0] wr_be,
    input  logic              inj_en,
    input  logic [IDX_W-1:0]  inj_idx,
    input  logic [BIT_W-1:0]  inj_bit,
    output logic              busy,
    output logic              rd_valid,
    output logic [WBITS-1:0]  rd_data,
    output logic [WBYTES-1:0] rd_err_mask,
    output logic              rd_err,
    output logic              rd_inval,
    output logic              wr_done,
    output logic              wr_reject,
    output logic [WBYTES-1:0] wr_err_mask,
    output logic              wr_err
);

    logic              seq_busy;
    logic [IDX_W-1:0]  seq_idx;
    logic [SEL_W-1:0]  seq_sel;
    logic              seq_we;
    logic [WBITS-1:0]  seq_wdata;
    logic [WBYTES-1:0] seq_wpar;
    logic              seq_done;
    logic [WBYTES-1:0] seq_mask;

    logic [IDX_W-1:0]  port_idx;
    logic [SEL_W-1:0]  port_sel;
    logic [WBITS-1:0]  port_data;
    logic [WBYTES-1:0] port_par;
    logic [WBYTES-1:0] port_err;
    logic [LINES-1:0]  line_valid;

    logic acc_fill, acc_wr, acc_rd, acc_inj, wr_start, wr_rej;

    // request arbitration: fill > write > read; inject yields to fill/write
    assign acc_fill = fill_en & ~seq_busy;
    assign acc_wr   = wr_en & ~seq_busy & ~fill_en;
    assign acc_rd   = rd_en & ~seq_busy & ~fill_en & ~wr_en;
    assign acc_inj  = inj_en & ~seq_busy & ~fill_en & ~wr_en;
    assign wr_start = acc_wr & line_valid[wr_idx];
    assign wr_rej   = acc_wr & ~line_valid[wr_idx];

    // single word port shared between reads and the write sequence
    assign port_idx = seq_busy ? seq_idx : rd_idx;
    assign port_sel = seq_busy ? seq_sel : rd_sel;

    pl_store #(.LINES(LINES), .WORDS(WORDS), .WBYTES(WBYTES)) u_store (
        .clk        (clk),
        .rst        (rst),
        .fill_we    (acc_fill),
        .fill_idx   (fill_idx),
        .fill_line  (fill_line),
        .word_we    (seq_we),
        .word_idx   (seq_idx),
        .word_sel   (seq_sel),
        .word_data  (seq_wdata),
        .word_par   (seq_wpar),
        .inj_we     (acc_inj),
        .inj_idx    (inj_idx),
        .inj_bit    (inj_bit),
        .rd_idx     (port_idx),
        .rd_sel     (port_sel),
        .rd_data    (port_data),
        .rd_par     (port_par),
        .line_valid (line_valid)
    );

    pl_par_check #(.WBYTES(WBYTES)) u_rd_chk (
        .data (port_data),
        .par  (port_par),
        .err  (port_err)
    );

    pl_pw_seq #(.LINES(LINES), .WORDS(WORDS), .WBYTES(WBYTES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (wr_start),
        .st_idx    (wr_idx),
        .st_sel    (wr_sel),
        .st_data   (wr_data),
        .st_be     (wr_be),
        .old_data  (port_data),
        .old_par   (port_par),
        .busy      (seq_busy),
        .cur_idx   (seq_idx),
        .cur_sel   (seq_sel),
        .word_we   (seq_we),
        .word_data (seq_wdata),
        .word_par  (seq_wpar),
        .done      (seq_done),
        .done_mask (seq_mask)
    );

    logic              rdv_q, rinv_q, rej_q;
    logic [WBITS-1:0]  rdd_q;
    logic [WBYTES-1:0] rdm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdv_q  <= 1'b0;
            rinv_q <= 1'b0;
            rdd_q  <= '0;
            rdm_q  <= '0;
            rej_q  <= 1'b0;
        end else begin
            rdv_q  <= acc_rd;
            rinv_q <= acc_rd & ~line_valid[rd_idx];
            rdd_q  <= (acc_rd & line_valid[rd_idx]) ? port_data : '0;
            rdm_q  <= (acc_rd & line_valid[rd_idx]) ? port_err : '0;
            rej_q  <= wr_rej;
        end
    end

    assign busy        = seq_busy;
    assign rd_valid    = rdv_q;
    assign rd_data     = rdd_q;
    assign rd_err_mask = rdm_q;
    assign rd_err      = |rdm_q;
    assign rd_inval    = rinv_q;
    assign wr_done     = seq_done | rej_q;
    assign wr_reject   = rej_q;
    assign wr_err_mask = seq_mask;
    assign wr_err      = |seq_mask;

endmodule

// File: rtl/pl_bank_chk.sv
module pl_bank_chk #(
    parameter int LINES  = 8,
    parameter int WORDS  = 4,
    parameter int WBYTES = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int WBITS = WBYTES * 8
) (
    input logic              clk,
    input logic              rst,
    input logic              fill_en,
    input logic              rd_en,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [LINES-1:0]  line_valid,
    input logic              busy,
    input logic              rd_valid,
    input logic [WBITS-1:0]  rd_data,
    input logic [WBYTES-1:0] rd_err_mask,
    input logic              rd_inval,
    input logic              wr_done,
    input logic              wr_reject,
    input logic [WBYTES-1:0] wr_err_mask
);

    // R7
    busy_three_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy ##1 busy ##1 !busy);

    // R7
    done_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (wr_done && !wr_reject));

    // R3
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en && !busy && !fill_en && !wr_en));

    // R8
    no_read_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !busy);

    // R5
    inval_clean_chk: assert property (@(posedge clk) disable iff (rst)
        rd_inval |-> (rd_valid && rd_data == '0 && rd_err_mask == '0));

    // R10
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && !fill_en && !line_valid[wr_idx]) |=> (wr_reject && wr_done && !busy));

    // R9
    wr_mask_only_done_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_err_mask != '0) |-> (wr_done && !wr_reject));

endmodule

bind parity_line_bank pl_bank_chk #(.LINES(LINES), .WORDS(WORDS), .WBYTES(WBYTES)) u_bank_chk (
    .clk         (clk),
    .rst         (rst),
    .fill_en     (fill_en),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .line_valid  (line_valid),
    .busy        (busy),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .rd_err_mask (rd_err_mask),
    .rd_inval    (rd_inval),
    .wr_done     (wr_done),
    .wr_reject   (wr_reject),
    .wr_err_mask (wr_err_mask)
);

// File: tb/parity_line_bank_test.sv
module parity_line_bank_test;

    localparam int CLK_P  = 10;
    localparam int LN     = 4;
    localparam int WD     = 2;
    localparam int WB     = 4;
    localparam int IDX_W  = $clog2(LN);
    localparam int SEL_W  = $clog2(WD);
    localparam int WBITS  = WB * 8;
    localparam int LBYTES = WD * WB;
    localparam int LBITS  = LBYTES * 8;
    localparam int BIT_W  = $clog2(LBITS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fill_en = 1'b0, rd_en = 1'b0, wr_en = 1'b0, inj_en = 1'b0;
    logic [IDX_W-1:0] fill_idx = '0, rd_idx = '0, wr_idx = '0, inj_idx = '0;
    logic [LBITS-1:0] fill_line = '0;
    logic [SEL_W-1:0] rd_sel = '0, wr_sel = '0;
    logic [WBITS-1:0] wr_data = '0;
    logic [WB-1:0]    wr_be = '0;
    logic [BIT_W-1:0] inj_bit = '0;
    logic busy, rd_valid, rd_err, rd_inval, wr_done, wr_reject, wr_err;
    logic [WBITS-1:0] rd_data;
    logic [WB-1:0]    rd_err_mask, wr_err_mask;

    always #(CLK_P/2) clk = ~clk;

    parity_line_bank #(.LINES(LN), .WORDS(WD), .WBYTES(WB)) uut (
        .clk(clk), .rst(rst),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_line(fill_line),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_sel(rd_sel),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_data(wr_data), .wr_be(wr_be),
        .inj_en(inj_en), .inj_idx(inj_idx), .inj_bit(inj_bit),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .rd_err_mask(rd_err_mask),
        .rd_err(rd_err), .rd_inval(rd_inval), .wr_done(wr_done), .wr_reject(wr_reject),
        .wr_err_mask(wr_err_mask), .wr_err(wr_err)
    );

    // reference model
    logic [LBITS-1:0]  m_data [LN];
    logic [LBYTES-1:0] m_par  [LN];
    logic [LN-1:0]     m_val;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [WB-1:0] word_par_of(input logic [WBITS-1:0] w);
        logic [WB-1:0] p;
        for (int k = 0; k < WB; k++) p[k] = ^w[k*8 +: 8];
        return p;
    endfunction

    function automatic logic [WBITS-1:0] m_word(input int l, input int s);
        return m_data[l][s*WBITS +: WBITS];
    endfunction

    function automatic logic [WB-1:0] m_wpar(input int l, input int s);
        return m_par[l][s*WB +: WB];
    endfunction

    function automatic logic [WB-1:0] m_errs(input int l, input int s);
        return word_par_of(m_word(l, s)) ^ m_wpar(l, s);
    endfunction

    task automatic do_fill(input int l, input logic [LBITS-1:0] v);
        @(negedge clk);
        fill_en = 1; fill_idx = IDX_W'(l); fill_line = v;
        @(negedge clk);
        fill_en = 0;
        m_data[l] = v;
        for (int g = 0; g < LBYTES; g++) m_par[l][g] = ^v[g*8 +: 8];
        m_val[l] = 1'b1;
    endtask

    // R3 R4 R5 read with check of the response one cycle later
    task automatic do_read(input int l, input int s);
        @(negedge clk);
        rd_en = 1; rd_idx = IDX_W'(l); rd_sel = SEL_W'(s);
        @(negedge clk);
        rd_en = 0;
        chk(rd_valid == 1'b1, "R3 rd_valid", 64'(rd_valid), 64'd1);
        if (m_val[l]) begin
            chk(rd_data == m_word(l, s), "R3 rd_data", 64'(rd_data), 64'(m_word(l, s)));
            chk(rd_err_mask == m_errs(l, s), "R4 rd_err_mask", 64'(rd_err_mask), 64'(m_errs(l, s)));
            chk(rd_err == (|m_errs(l, s)), "R4 rd_err", 64'(rd_err), 64'(|m_errs(l, s)));
            chk(rd_inval == 1'b0, "R5 rd_inval", 64'(rd_inval), 64'd0);
        end else begin
            chk(rd_inval == 1'b1 && rd_data == '0 && rd_err_mask == '0, "R5 invalid read",
                64'(rd_data), 64'd0);
        end
    endtask

    task automatic do_write(input int l, input int s, input logic [WBITS-1:0] d, input logic [WB-1:0] be);
        logic [WBITS-1:0] merged;
        logic [WB-1:0] expm;
        @(negedge clk);
        wr_en = 1; wr_idx = IDX_W'(l); wr_sel = SEL_W'(s); wr_data = d; wr_be = be;
        @(negedge clk);
        wr_en = 0;
        if (!m_val[l]) begin
            chk(wr_done && wr_reject && !busy, "R10 reject", {61'd0, wr_done, wr_reject, busy}, 64'd6);
            return;
        end
        chk(busy, "R7 busy c1", 64'(busy), 64'd1);
        @(negedge clk);
        chk(busy && !wr_done, "R7 busy c2", 64'(busy), 64'd1);
        @(negedge clk);
        chk(busy && !wr_done, "R7 busy c3", 64'(busy), 64'd1);
        @(negedge clk);
        expm = m_errs(l, s);
        chk(!busy && wr_done && !wr_reject, "R7 done", {62'd0, busy, wr_done}, 64'd1);
        chk(wr_err_mask == expm, "R9 wr_err_mask", 64'(wr_err_mask), 64'(expm));
        chk(wr_err == (|expm), "R9 wr_err", 64'(wr_err), 64'(|expm));
        for (int k = 0; k < WB; k++)
            merged[k*8 +: 8] = be[k] ? d[k*8 +: 8] : m_word(l, s)[k*8 +: 8];
        m_data[l][s*WBITS +: WBITS] = merged;
        m_par[l][s*WB +: WB] = word_par_of(merged);
    endtask

    task automatic do_inject(input int l, input int b);
        @(negedge clk);
        inj_en = 1; inj_idx = IDX_W'(l); inj_bit = BIT_W'(b);
        @(negedge clk);
        inj_en = 0;
        m_data[l][b] = ~m_data[l][b];
    endtask

    function automatic logic [LBITS-1:0] rnd_line();
        logic [LBITS-1:0] v;
        for (int i = 0; i < LBITS; i += 32) v[i +: 32] = $urandom();
        return v;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                finish_run();
            end
        end
    end

    initial begin
        logic [WBITS-1:0] tmp;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < LN; i++) begin m_data[i] = '0; m_par[i] = '0; end
        m_val = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(!busy && !rd_valid && !wr_done && !wr_reject, "R1 reset outputs",
            {60'd0, busy, rd_valid, wr_done, wr_reject}, 64'd0);
        for (int l = 0; l < LN; l++) do_read(l, 0);          // R1 R5 all invalid
        do_write(2, 1, 32'hAABBCCDD, 4'hF);                  // R10 write to invalid line
        do_read(2, 1);                                        // R10 line still invalid

        // R2 fill, parity checked clean on read
        do_fill(0, 64'h0123_4567_89AB_CDEF);
        do_fill(1, 64'hFFFF_FFFF_0000_0001);
        do_read(0, 0); do_read(0, 1); do_read(1, 1);

        // R12 inject first and last bit, R4 masks flag those bytes
        do_inject(1, 0);
        do_inject(1, LBITS - 1);
        do_read(1, 0); do_read(1, 1);
        chk(m_errs(1, 1) == 4'b1000, "R12 model expects top byte flagged", 64'(m_errs(1, 1)), 64'h8);

        // R9 R6 partial write over a corrupted word keeps bad byte, reports it
        do_write(1, 1, 32'h1122_3344, 4'b0011);
        do_read(1, 1);                                        // R6 clean after rewrite
        do_write(0, 0, 32'hDEAD_BEEF, 4'b0101);
        do_read(0, 0);

        // R8 requests while busy are ignored
        @(negedge clk);
        wr_en = 1; wr_idx = 0; wr_sel = 1; wr_data = 32'h5555_AAAA; wr_be = 4'b1111;
        @(negedge clk);
        wr_en = 0;
        fill_en = 1; fill_idx = 0; fill_line = '1;
        rd_en = 1; rd_idx = 1; rd_sel = 0;
        inj_en = 1; inj_idx = 1; inj_bit = 3;
        @(negedge clk);
        chk(!rd_valid, "R8 read ignored while busy", 64'(rd_valid), 64'd0);
        fill_en = 0; rd_en = 0; inj_en = 0;
        @(negedge clk); @(negedge clk);
        chk(wr_done, "R8 write finished", 64'(wr_done), 64'd1);
        m_data[0][WBITS +: WBITS] = 32'h5555_AAAA;
        m_par[0][WB +: WB] = word_par_of(32'h5555_AAAA);
        do_read(0, 0); do_read(0, 1); do_read(1, 0);          // fill and inject had no effect

        // R11 priority: fill beats write/read, inject dropped
        @(negedge clk);
        fill_en = 1; fill_idx = 3; fill_line = 64'hCAFE_F00D_1234_5678;
        wr_en = 1; wr_idx = 0; wr_sel = 0; wr_data = 32'h0; wr_be = 4'hF;
        rd_en = 1; rd_idx = 0; rd_sel = 0;
        inj_en = 1; inj_idx = 0; inj_bit = 9;
        @(negedge clk);
        fill_en = 0; wr_en = 0; rd_en = 0; inj_en = 0;
        chk(!busy && !rd_valid && !wr_done, "R11 fill wins", {61'd0, busy, rd_valid, wr_done}, 64'd0);
        m_data[3] = 64'hCAFE_F00D_1234_5678;
        for (int g = 0; g < LBYTES; g++) m_par[3][g] = ^m_data[3][g*8 +: 8];
        m_val[3] = 1;
        do_read(3, 1); do_read(0, 0);
        // R11 write beats read
        @(negedge clk);
        wr_en = 1; wr_idx = 3; wr_sel = 0; wr_data = 32'h0F0F_0F0F; wr_be = 4'b1000;
        rd_en = 1; rd_idx = 3; rd_sel = 0;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        chk(busy && !rd_valid, "R11 write wins over read", {62'd0, busy, rd_valid}, 64'd2);
        repeat (3) @(negedge clk);
        tmp = m_word(3, 0); tmp[31:24] = 8'h0F;
        m_data[3][0 +: WBITS] = tmp; m_par[3][0 +: WB] = word_par_of(tmp);
        // R11 read and inject together both act
        @(negedge clk);
        rd_en = 1; rd_idx = 3; rd_sel = 0;
        inj_en = 1; inj_idx = 3; inj_bit = 5;
        @(negedge clk);
        rd_en = 0; inj_en = 0;
        chk(rd_valid && rd_data == m_word(3, 0), "R11 read with inject sees old",
            64'(rd_data), 64'(m_word(3, 0)));
        m_data[3][5] = ~m_data[3][5];
        do_read(3, 0);

        // constrained random traffic
        for (int n = 0; n < 400; n++) begin
            int op, l, s;
            op = $urandom_range(0, 9); l = $urandom_range(0, LN - 1); s = $urandom_range(0, WD - 1);
            if (op == 0)      do_fill(l, rnd_line());
            else if (op <= 4) do_read(l, s);
            else if (op <= 7) do_write(l, s, $urandom(), 4'($urandom_range(0, 15)));
            else              do_inject(l, $urandom_range(0, LBITS - 1));
        end
        for (int l = 0; l < LN; l++) for (int s = 0; s < WD; s++) do_read(l, s);
        finish_run();
    end

endmodule